// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This block adds or subtracts two numbers held in sign-magnitude form. Each number has a sign bit (1 = negative) and an unsigned magnitude of `MAG_W` bits. A caller pulses `start` for one clock. On that edge the block captures both operands and the mode. It then runs a fixed sequence of two internal steps, computing and then correcting, and pulses `done` for one clock. The result has the same sign-magnitude form and stays on the outputs until the next accepted operation.

Subtraction is handled as an addition with the second operand's sign inverted. If the two effective signs agree, the magnitudes are added and the carry out of the top bit is reported as overflow. If the signs differ, the second magnitude is subtracted through its two's complement. The end carry then shows which magnitude was larger. When the second magnitude was larger, the block negates the difference in a second pass through the same adder and flips the sign. A zero difference always comes out as positive zero.

Top module: `sm_addsub`

## Requirements
- R1: While reset is asserted, `done`, `ovf`, `res_sign` and `res_mag` are all 0.
- R2: A `start` seen while idle produces exactly one `done` pulse, one clock wide, three clock edges after the sampling edge. The result outputs keep their value after `done` until the next accepted `start`.
- R3: `mode` = 0 gives the sum of the two operands and `mode` = 1 gives the first minus the second. Whenever no overflow occurs, the value of the result as a signed integer equals that sum or difference.
- R4: If the first operand's sign equals the effective sign of the second (its sign XOR `mode`), the result magnitude is the sum of the magnitudes modulo 2^MAG_W, and the result sign is the first operand's sign.
- R5: On that equal-sign path, `ovf` equals the carry out of the magnitude sum. On the differing-sign path, `ovf` is 0.
- R6: If the effective signs differ and the first magnitude is greater than the second, the result magnitude is the first minus the second, and the sign is the first operand's sign.
- R7: If the effective signs differ and the first magnitude is smaller, the result magnitude is the second minus the first, and the sign is the inverse of the first operand's sign.
- R8: If the effective signs differ and the magnitudes are equal, the result is positive zero (sign 0, magnitude 0).
- R9: Operand and mode inputs are sampled only on the accepted `start` edge. A `start` raised while an operation is in progress is ignored and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of first operand (1 = negative) |
| a_mag | input | MAG_W | Magnitude of first operand |
| b_sign | input | 1 | Sign of second operand (1 = negative) |
| b_mag | input | MAG_W | Magnitude of second operand |
| done | output | 1 | One-cycle pulse when the result is valid |
| res_sign | output | 1 | Result sign |
| res_mag | output | MAG_W | Result magnitude |
| ovf | output | 1 | Magnitude overflow on equal-sign addition |

## Verification
The bench builds the block with `MAG_W` = 8. This keeps the full magnitude range small enough that the all-ones corner (255 + 255) and exact-carry cases such as 128 + 128 are reached directly. At this width the bench sweeps both modes against all four sign pairs, with larger, smaller and equal magnitudes. A pseudo-random stream of operands is then compared with a signed-integer model, and a burst of `start` pulses is sent during a busy operation.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

  // Sequencer phases: wait for a request, run the adder, apply the fix-up
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_FIX  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sm_mag_adder.sv
// Ripple adder with an optional one's complement of its second input.
// Together with cin = 1 this forms x - y or -y in two's complement.
module sm_mag_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         inv_y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W:0]   carry;
  logic [W-1:0] y_eff;

  assign carry[0] = cin_i;
  assign y_eff    = inv_y_i ? ~y_i : y_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]   = x_i[i] ^ y_eff[i] ^ carry[i];
    assign carry[i+1] = (x_i[i] & y_eff[i]) | (carry[i] & (x_i[i] ^ y_eff[i]));
  end

  assign cout_o = carry[W];

endmodule

// File: rtl/sm_addsub_seq.sv
module sm_addsub_seq
  import sm_addsub_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_en_o,
  output logic calc_en_o,
  output logic fix_en_o,
  output logic done_o
);

  seq_state_e state_q, state_d;
  logic       done_q, done_d;

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    load_en_o = 1'b0;
    calc_en_o = 1'b0;
    fix_en_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en_o = 1'b1;
          state_d   = ST_CALC;
        end
      end
      ST_CALC: begin
        calc_en_o = 1'b1;
        state_d   = ST_FIX;
      end
      ST_FIX: begin
        fix_en_o = 1'b1;
        done_d   = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;

  // R2
  start_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_IDLE) |-> ##3 done_q);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_CALC));

endmodule

// File: rtl/sm_addsub_core.sv
module sm_addsub_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en_i,
  input  logic         calc_en_i,
  input  logic         fix_en_i,
  input  logic         sub_i,
  input  logic         a_sign_i,
  input  logic [W-1:0] a_mag_i,
  input  logic         b_sign_i,
  input  logic [W-1:0] b_mag_i,
  output logic         res_sign_o,
  output logic [W-1:0] res_mag_o,
  output logic         ovf_o
);

  // Operand and result registers
  logic         as_q, as_d;
  logic [W-1:0] a_q,  a_d;
  logic         bs_q, bs_d;
  logic [W-1:0] b_q,  b_d;
  logic         e_q,  e_d;
  logic         avf_q, avf_d;
  logic         diff_q, diff_d;

  // Shared adder
  logic         signs_differ;
  logic [W-1:0] add_x, add_y, add_sum;
  logic         add_inv, add_cin, add_cout;

  assign signs_differ = as_q ^ bs_q;

  // In the fix pass the adder forms 0 + ~A + 1, the negation of A
  always_comb begin
    if (fix_en_i) begin
      add_x   = '0;
      add_y   = a_q;
      add_inv = 1'b1;
      add_cin = 1'b1;
    end else begin
      add_x   = a_q;
      add_y   = b_q;
      add_inv = signs_differ;
      add_cin = signs_differ;
    end
  end

  sm_mag_adder #(.W(W)) u_adder (
    .x_i    (add_x),
    .y_i    (add_y),
    .inv_y_i(add_inv),
    .cin_i  (add_cin),
    .sum_o  (add_sum),
    .cout_o (add_cout)
  );

  always_comb begin
    as_d   = as_q;
    a_d    = a_q;
    bs_d   = bs_q;
    b_d    = b_q;
    e_d    = e_q;
    avf_d  = avf_q;
    diff_d = diff_q;
    if (load_en_i) begin
      as_d = a_sign_i;
      a_d  = a_mag_i;
      bs_d = b_sign_i ^ sub_i;
      b_d  = b_mag_i;
    end else if (calc_en_i) begin
      a_d    = add_sum;
      e_d    = add_cout;
      diff_d = signs_differ;
      avf_d  = signs_differ ? 1'b0 : add_cout;
    end else if (fix_en_i) begin
      if (diff_q) begin
        if (!e_q) begin
          a_d  = add_sum;
          as_d = ~as_q;
        end
        if (a_d == '0) begin
          as_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q   <= 1'b0;
      a_q    <= '0;
      bs_q   <= 1'b0;
      b_q    <= '0;
      e_q    <= 1'b0;
      avf_q  <= 1'b0;
      diff_q <= 1'b0;
    end else begin
      as_q   <= as_d;
      a_q    <= a_d;
      bs_q   <= bs_d;
      b_q    <= b_d;
      e_q    <= e_d;
      avf_q  <= avf_d;
      diff_q <= diff_d;
    end
  end

  assign res_sign_o = as_q;
  assign res_mag_o  = a_q;
  assign ovf_o      = avf_q;

  // R5
  diff_path_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_en_i && (as_q != bs_q)) |=> !avf_q);

  // R6
  larger_a_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en_i && diff_q && e_q && (a_q != '0)) |=> ($stable(a_q) && $stable(as_q)));

  // R7
  smaller_a_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en_i && diff_q && !e_q) |=> (as_q != $past(as_q)));

  // R8
  zero_is_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en_i && diff_q) |=> !((a_q == '0) && as_q));

endmodule

// File: rtl/sm_addsub.sv
module sm_addsub #(
  parameter int MAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             done,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             ovf
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  logic                   load_en, calc_en, fix_en;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  sm_addsub_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start),
    .load_en_o(load_en),
    .calc_en_o(calc_en),
    .fix_en_o (fix_en),
    .done_o   (done)
  );

  sm_addsub_core #(.W(MAG_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load_en_i (load_en),
    .calc_en_i (calc_en),
    .fix_en_i  (fix_en),
    .sub_i     (mode),
    .a_sign_i  (a_sign),
    .a_mag_i   (a_mag),
    .b_sign_i  (b_sign),
    .b_mag_i   (b_mag),
    .res_sign_o(res_sign),
    .res_mag_o (res_mag),
    .ovf_o     (ovf)
  );

endmodule

// File: tb/sm_addsub_test.sv
`timescale 1ns/1ps
module sm_addsub_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic         a_sign = 1'b0;
  logic [W-1:0] a_mag = '0;
  logic         b_sign = 1'b0;
  logic [W-1:0] b_mag = '0;
  logic         done, res_sign, ovf;
  logic [W-1:0] res_mag;

  always #2.5 clk = ~clk;

  sm_addsub #(.MAG_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
    .done(done), .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf)
  );

  typedef struct {
    logic         s;
    logic [W-1:0] m;
    logic         v;
    int           cyc;
    string        tag;
    int           ref_val;
    bit           ref_ok;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  bit   finished = 0;

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Expected result from the requirement rules R4..R8
  function automatic exp_t model(input bit md, input bit as, input int am,
                                 input bit bs, input int bm);
    exp_t e;
    bit   ebs;
    int   sa, sb;
    ebs = bs ^ md;
    if (as == ebs) begin
      e.m   = W'(am + bm);
      e.v   = ((am + bm) >= (1 << W));
      e.s   = as;
      e.tag = e.v ? "R5" : "R4";
    end else if (am > bm) begin
      e.m = W'(am - bm); e.v = 0; e.s = as;  e.tag = "R6";
    end else if (am < bm) begin
      e.m = W'(bm - am); e.v = 0; e.s = ~as; e.tag = "R7";
    end else begin
      e.m = '0; e.v = 0; e.s = 0; e.tag = "R8";
    end
    sa = as ? -am : am;
    sb = bs ? -bm : bm;
    e.ref_val = md ? (sa - sb) : (sa + sb);
    e.ref_ok  = !e.v;
    return e;
  endfunction

  // Monitor: pop and compare whenever done is seen
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(0, "R9", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        int   got;
        e = q.pop_front();
        check(res_mag == e.m, e.tag, "magnitude", int'(res_mag), int'(e.m));
        check(res_sign == e.s, e.tag, "sign", int'(res_sign), int'(e.s));
        check(ovf == e.v, "R5", "overflow", int'(ovf), int'(e.v));
        check(cyc - e.cyc == 3, "R2", "latency", cyc - e.cyc, 3);
        if (e.ref_ok) begin
          got = res_sign ? -int'(res_mag) : int'(res_mag);
          check(got == e.ref_val, "R3", "signed value", got, e.ref_val);
        end
        last_exp = e;
      end
    end
  end

  // Driver: pulse start, scramble inputs afterwards, wait for completion
  task automatic issue(input bit md, input bit as, input int am,
                       input bit bs, input int bm, input int busy_pulses);
    exp_t e;
    @(negedge clk);
    start = 1; mode = md; a_sign = as; a_mag = W'(am); b_sign = bs; b_mag = W'(bm);
    e = model(md, as, am, bs, bm);
    e.cyc = cyc;
    q.push_back(e);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      // R9: inputs change after sampling; extra starts only while busy
      start  = (k < busy_pulses);
      mode   = ~md;
      a_sign = ~as; a_mag = W'(am) ^ 8'hA5;
      b_sign = ~bs; b_mag = W'(bm) ^ 8'h3C;
    end
    start = 0;
    @(negedge clk);
    // R2: result held after done
    check(!done, "R2", "done width", int'(done), 0);
    check(res_mag == last_exp.m && res_sign == last_exp.s, "R2", "hold",
          int'(res_mag), int'(last_exp.m));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int pairs_a[6] = '{200, 55, 77, 255, 128, 0};
    int pairs_b[6] = '{55, 200, 77, 255, 128, 0};
    logic [15:0] lfsr = 16'hACE1;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!done && !ovf && !res_sign && res_mag == '0, "R1", "reset outputs",
          int'({done, ovf, res_sign}) + int'(res_mag), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // Every mode and sign pair with larger, smaller, equal and max magnitudes
    for (int md = 0; md < 2; md++)
      for (int as = 0; as < 2; as++)
        for (int bs = 0; bs < 2; bs++)
          for (int p = 0; p < 6; p++)
            issue(md[0], as[0], pairs_a[p], bs[0], pairs_b[p], 0);

    // R9: start pulses during both busy cycles are ignored
    issue(1'b1, 1'b0, 30, 1'b0, 90, 2);
    issue(1'b0, 1'b1, 255, 1'b1, 1, 2);

    // Pseudo-random operands
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(lfsr[0], lfsr[1], int'(lfsr[15:8]), lfsr[2], int'(lfsr[11:4]), 0);
    end

    repeat (4) @(negedge clk);
    // R2 and R9: every accepted start produced exactly one done
    check(q.size() == 0, "R9", "pending results", q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule